// File: doc/BRIEF.md
# Parallel NAND Flash Bus Sequencer

This block sits on the host side of an 8-bit parallel NAND flash device. It turns one front-end request into the strobe sequence that the flash expects. A request can carry a single command byte, a four-byte address, a burst of bytes to write, or a burst of bytes to read. The request is offered on a valid/ready handshake. While the request runs, the block drives chip enable, the command and address latch lines, and the write and read strobes. It also drives or releases the I/O bus and captures the bytes the flash returns.

Each byte cycle has three phases: a setup phase, a strobe-low phase and a hold phase. The length of each phase is a clock-count parameter, so one netlist can be retimed for different flash speed grades. After a request, the block can optionally wait for the ready/busy pin to go high before it takes the next request. A timeout counter bounds that wait.

Top module: `nfc_bus_seq`

## Requirements
- R1: While reset is applied and after its release, chip enable, write strobe and read strobe are high (inactive), both latch lines are low, the I/O output enable is low and `req_ready` is high.
- R2: A command request (`req_kind` = 0) makes one byte cycle. Chip enable is low, the command latch is high, the address latch is low and the read strobe is high. `req_cmd` is driven on the I/O bus and is latched by exactly one write-strobe rising edge.
- R3: An address request (`req_kind` = 1) makes exactly four write-strobe pulses with the address latch high and the command latch low. Bits 7:0 of `req_addr` go out first, then 15:8, then 23:16, then 31:24.
- R4: A write request (`req_kind` = 2) makes `req_len` write-strobe pulses with both latch lines low and the bus driven. Byte k is the value on `wr_data` when the block takes it. `wr_take` pulses once per byte, in the cycle after that byte was captured, and the host must then present the next byte.
- R5: A read request (`req_kind` = 3) makes `req_len` read-strobe pulses with the write strobe high and both latch lines low. Each `rd_data` value equals `nand_io_in` as it was in the last strobe-low cycle before the read strobe rises. `rd_valid` pulses once per byte.
- R6: Every strobe-low pulse lasts exactly T_LOW cycles. Chip enable falls T_SETUP cycles before the first pulse. Pulses inside one request are T_HOLD+T_SETUP cycles apart, and chip enable rises T_HOLD cycles after the last pulse. The latch lines do not change around a write-strobe rising edge.
- R7: `req_ready` is low from the cycle after a request is accepted until the request is finished, including any ready/busy wait. With the wait flag clear, a request of n byte cycles holds `req_ready` low for n*(T_SETUP+T_LOW+T_HOLD) cycles.
- R8: A write or read request with `req_len` = 0 and the wait flag clear finishes at once: `req_ready` is high again in the next cycle and no strobe or chip enable moves.
- R9: With `req_wait_rb` set, `req_ready` stays low after the last byte cycle until `nand_rb` is seen high. That pin passes through a two-stage synchronizer, so `req_ready` returns three cycles after `nand_rb` rises.
- R10: If `nand_rb` stays low for RB_TIMEOUT cycles of the wait, `rb_timeout` pulses for one cycle and `req_ready` returns high in the next cycle.
- R11: The write and read strobes are never low together, and the I/O output enable is never high while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 2 | 0 command, 1 address, 2 write burst, 3 read burst |
| req_cmd | input | 8 | Command byte |
| req_addr | input | 32 | Four address bytes, low byte sent first |
| req_len | input | LEN_W | Burst byte count for write/read |
| req_wait_rb | input | 1 | Wait for ready/busy high after the request |
| wr_data | input | 8 | Next byte of a write burst |
| wr_take | output | 1 | Pulse: one write byte consumed |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| rb_timeout | output | 1 | Pulse: ready/busy wait expired |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value when driven |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus value from the flash |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The assertions watch, on every cycle, the bus rules that do not depend on a request's history. The two strobes must never be low together, the bus must be released whenever the read strobe is low, and both latch lines must never be high at once. A strobe may go low only under chip enable, the latch lines and bus value must hold across a write pulse, `req_ready` must be low while chip enable is low, and `req_ready` must return after a timeout. Other properties need a model of what the request asked for: pulse counts, byte order and values, exact phase lengths, the length of the busy period, zero-length bursts and how ready/busy is released. Only the bench's sweeps over commands, address patterns and burst lengths can show these.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BYTE = 2'd1,
    ST_RBW  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_LOW   = 2'd1,
    PH_HOLD  = 2'd2
  } strobe_phase_e;

  localparam int ADDR_BYTES = 4;

endpackage

// File: rtl/nfc_rst_sync.sv
module nfc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/nfc_strobe_timer.sv
module nfc_strobe_timer
  import nfc_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 2,
  parameter int T_HOLD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe_low,
  output logic sample,
  output logic byte_end
);

  localparam int T_MAX = (T_SETUP > T_LOW) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                           : ((T_LOW > T_HOLD) ? T_LOW : T_HOLD);
  localparam int CW = $clog2(T_MAX + 1);

  strobe_phase_e ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_last;

  always_comb begin
    case (ph_q)
      PH_SETUP: ph_last = (cnt_q == CW'(T_SETUP - 1));
      PH_LOW:   ph_last = (cnt_q == CW'(T_LOW - 1));
      default:  ph_last = (cnt_q == CW'(T_HOLD - 1));
    endcase
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!run) begin
      ph_d  = PH_SETUP;
      cnt_d = '0;
    end else if (ph_last) begin
      cnt_d = '0;
      case (ph_q)
        PH_SETUP: ph_d = PH_LOW;
        PH_LOW:   ph_d = PH_HOLD;
        default:  ph_d = PH_SETUP;
      endcase
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SETUP;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign strobe_low = run && (ph_q == PH_LOW);
  assign sample     = strobe_low && ph_last;
  assign byte_end   = run && (ph_q == PH_HOLD) && ph_last;

endmodule

// File: rtl/nfc_rb_wait.sv
module nfc_rb_wait #(
  parameter int RB_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rb_pin,
  output logic done,
  output logic expired
);

  localparam int TW = $clog2(RB_TIMEOUT + 1);

  logic          rb_meta_q;
  logic          rb_sync_q;
  logic [TW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_meta_q <= 1'b0;
      rb_sync_q <= 1'b0;
    end else begin
      rb_meta_q <= rb_pin;
      rb_sync_q <= rb_meta_q;
    end
  end

  always_comb begin
    if (active) cnt_d = cnt_q + TW'(1);
    else        cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = active && !rb_sync_q && (cnt_q == TW'(RB_TIMEOUT - 1));
  assign done    = active && (rb_sync_q || expired);

endmodule

// File: rtl/nfc_bus_seq.sv
module nfc_bus_seq
  import nfc_pkg::*;
#(
  parameter int T_SETUP    = 2,
  parameter int T_LOW      = 2,
  parameter int T_HOLD     = 2,
  parameter int LEN_W      = 12,
  parameter int RB_TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [7:0]       req_cmd,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_wait_rb,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             rb_timeout,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb
);

  localparam int CNT_W = (LEN_W > 3) ? LEN_W : 3;

  logic srst_n;

  nfc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  seq_state_e       st_q, st_d;
  op_kind_e         kind_q, kind_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [31:0]      addr_q, addr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             wait_q, wait_d;
  logic [7:0]       wdat_q, wdat_d;
  logic [7:0]       rdat_q, rdat_d;
  logic             rvld_q, rvld_d;
  logic             take_q, take_d;

  logic in_byte, strobe_low, sample, byte_end;
  logic rb_done, rb_expired;
  logic accept, zero_len, start_bytes, more, next_byte, last_byte, load_wr;

  assign in_byte = (st_q == ST_BYTE);

  nfc_strobe_timer #(
    .T_SETUP (T_SETUP),
    .T_LOW   (T_LOW),
    .T_HOLD  (T_HOLD)
  ) u_timer (
    .clk        (clk),
    .rst_n      (srst_n),
    .run        (in_byte),
    .strobe_low (strobe_low),
    .sample     (sample),
    .byte_end   (byte_end)
  );

  nfc_rb_wait #(
    .RB_TIMEOUT (RB_TIMEOUT)
  ) u_rbw (
    .clk     (clk),
    .rst_n   (srst_n),
    .active  (st_q == ST_RBW),
    .rb_pin  (nand_rb),
    .done    (rb_done),
    .expired (rb_expired)
  );

  // request decode and byte bookkeeping
  always_comb begin
    accept      = req_valid && (st_q == ST_IDLE);
    zero_len    = req_kind[1] && (req_len == '0);
    start_bytes = accept && !zero_len;
    more        = (left_q != CNT_W'(1));
    next_byte   = byte_end && more;
    last_byte   = byte_end && !more;
    load_wr     = (start_bytes && (req_kind == OP_WR)) || (next_byte && (kind_q == OP_WR));
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    left_d = left_q;
    wait_d = wait_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    rvld_d = 1'b0;
    take_d = load_wr;

    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          kind_d = op_kind_e'(req_kind);
          cmd_d  = req_cmd;
          addr_d = req_addr;
          wait_d = req_wait_rb;
          case (op_kind_e'(req_kind))
            OP_CMD:  left_d = CNT_W'(1);
            OP_ADDR: left_d = CNT_W'(ADDR_BYTES);
            default: left_d = CNT_W'(req_len);
          endcase
          if (zero_len) st_d = req_wait_rb ? ST_RBW : ST_IDLE;
          else          st_d = ST_BYTE;
        end
      end
      ST_BYTE: begin
        if (next_byte) left_d = left_q - CNT_W'(1);
        if (byte_end && (kind_q == OP_ADDR)) addr_d = {8'h00, addr_q[31:8]};
        if (last_byte) st_d = wait_q ? ST_RBW : ST_IDLE;
      end
      ST_RBW: begin
        if (rb_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    if (load_wr) wdat_d = wr_data;
    if (sample && (kind_q == OP_RD)) begin
      rdat_d = nand_io_in;
      rvld_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= OP_CMD;
      cmd_q  <= '0;
      addr_q <= '0;
      left_q <= '0;
      wait_q <= 1'b0;
      wdat_q <= '0;
      rdat_q <= '0;
      rvld_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      left_q <= left_d;
      wait_q <= wait_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
      rvld_q <= rvld_d;
      take_q <= take_d;
    end
  end

  // pin drive
  always_comb begin
    nand_ce_n  = !in_byte;
    nand_cle   = in_byte && (kind_q == OP_CMD);
    nand_ale   = in_byte && (kind_q == OP_ADDR);
    nand_we_n  = !(strobe_low && (kind_q != OP_RD));
    nand_re_n  = !(strobe_low && (kind_q == OP_RD));
    nand_io_oe = in_byte && (kind_q != OP_RD);
    case (kind_q)
      OP_CMD:  nand_io_out = cmd_q;
      OP_ADDR: nand_io_out = addr_q[7:0];
      OP_WR:   nand_io_out = wdat_q;
      default: nand_io_out = 8'h00;
    endcase
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign wr_take    = take_q;
  assign rd_data    = rdat_q;
  assign rd_valid   = rvld_q;
  assign rb_timeout = rb_expired;

endmodule

// File: rtl/nfc_bus_seq_chk.sv
module nfc_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rb_timeout,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_io_out,
  input logic       nand_io_oe
);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R11
  bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R6
  strobe_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  // R6
  latch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale) && !nand_ce_n));

  // R2
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_io_out));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n |-> !req_ready);

  // R10
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_timeout |=> req_ready);

endmodule

bind nfc_bus_seq nfc_bus_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rb_timeout  (rb_timeout),
  .nand_ce_n   (nand_ce_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_io_out (nand_io_out),
  .nand_io_oe  (nand_io_oe)
);

// File: tb/tb_nfc_bus_seq.sv
module tb_nfc_bus_seq;

  localparam int TS  = 2;
  localparam int TL  = 3;
  localparam int TH  = 1;
  localparam int CYC = TS + TL + TH;
  localparam int LW  = 4;
  localparam int TO  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [7:0]    req_cmd = 8'd0;
  logic [31:0]   req_addr = 32'd0;
  logic [LW-1:0] req_len = '0;
  logic          req_wait_rb = 1'b0;
  logic [7:0]    wr_data;
  logic          wr_take;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic          rb_timeout;
  logic          nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]    nand_io_out;
  logic [7:0]    nand_io_in;
  logic          nand_rb = 1'b1;

  int nchecks = 0;
  int nerrs = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] fw(int i);
    return 8'((i * 29 + 3) & 255);
  endfunction

  function automatic logic [7:0] fr(int i);
    return 8'((i * 53 + 17) & 255);
  endfunction

  int widx = 0;
  int rcount = 0;
  int rbidx = 0;

  assign wr_data    = fw(widx);
  assign nand_io_in = fr(rcount);

  always #2 clk = ~clk;

  nfc_bus_seq #(
    .T_SETUP (TS), .T_LOW (TL), .T_HOLD (TH), .LEN_W (LW), .RB_TIMEOUT (TO)
  ) dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_kind (req_kind),
    .req_cmd (req_cmd), .req_addr (req_addr), .req_len (req_len),
    .req_wait_rb (req_wait_rb), .wr_data (wr_data), .wr_take (wr_take),
    .rd_data (rd_data), .rd_valid (rd_valid), .rb_timeout (rb_timeout),
    .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_ale (nand_ale),
    .nand_we_n (nand_we_n), .nand_re_n (nand_re_n), .nand_io_out (nand_io_out),
    .nand_io_oe (nand_io_oe), .nand_io_in (nand_io_in), .nand_rb (nand_rb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor
  logic [7:0] lg_val [16];
  bit         lg_cle [16];
  bit         lg_ale [16];
  bit         lg_oe  [16];
  int  lg_n = 0, re_pulses = 0, rd_n = 0, takes = 0, tocnt = 0, pulses = 0;
  int  lo_run = 0, hi_run = 0;
  bit  mon_on = 1'b0;
  logic p_we = 1'b1, p_re = 1'b1, p_cle = 1'b0, p_ale = 1'b0, p_oe = 1'b0;
  logic [7:0] p_io = 8'd0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_take) begin
        widx++;
        takes++;
      end
      if (rd_valid) begin
        chk(rd_data == fr(rbidx), "R5 read byte", rd_data, fr(rbidx));
        rbidx++;
        rd_n++;
      end
      if (!p_we && nand_we_n && lg_n < 16) begin
        lg_val[lg_n] = p_io;
        lg_cle[lg_n] = p_cle;
        lg_ale[lg_n] = p_ale;
        lg_oe[lg_n]  = p_oe;
        lg_n++;
      end
      if (!p_re && nand_re_n) begin
        rcount++;
        re_pulses++;
        chk(!p_cle && !p_ale && p_we, "R5 latch lines during read", {p_cle, p_ale}, 0);
      end
      if (!nand_re_n) chk(!nand_io_oe && nand_we_n, "R11 bus released under read strobe", nand_io_oe, 0);
      if (rb_timeout) tocnt++;
      if (!nand_ce_n) begin
        if (!nand_we_n || !nand_re_n) begin
          if (hi_run > 0) begin
            chk(hi_run == ((pulses == 0) ? TS : TH + TS), "R6 gap before pulse",
                hi_run, (pulses == 0) ? TS : TH + TS);
            hi_run = 0;
          end
          if (lo_run == 0) pulses++;
          lo_run++;
        end else begin
          if (lo_run > 0) begin
            chk(lo_run == TL, "R6 low width", lo_run, TL);
            lo_run = 0;
          end
          hi_run++;
        end
      end else begin
        if (hi_run > 0) chk(hi_run == TH, "R6 hold after last pulse", hi_run, TH);
        hi_run = 0;
        lo_run = 0;
        pulses = 0;
      end
      p_we = nand_we_n; p_re = nand_re_n; p_cle = nand_cle; p_ale = nand_ale;
      p_oe = nand_io_oe; p_io = nand_io_out;
    end
  end

  task automatic run_req(input int k, input logic [7:0] c, input logic [31:0] a,
                         input int len, input bit w, output int busy);
    while (!req_ready) @(negedge clk);
    lg_n = 0; re_pulses = 0; rd_n = 0; takes = 0; tocnt = 0;
    req_kind = 2'(k); req_cmd = c; req_addr = a; req_len = LW'(len);
    req_wait_rb = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready && busy < 1000) begin
      busy++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nerrs++;
      nchecks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

  initial begin
    int busy;
    int base;
    logic [31:0] a;
    logic [7:0] c;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe,
        "R1 pins in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 6'b111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    chk(req_ready && nand_ce_n && nand_we_n && nand_re_n && !nand_io_oe,
        "R1 idle after reset", {req_ready, nand_ce_n, nand_we_n, nand_re_n, nand_io_oe}, 5'b11110);
    mon_on = 1'b1;

    // R2 command sweep
    for (int i = 0; i < 8; i++) begin
      c = 8'((i * 37 + 5) & 255);
      run_req(0, c, 32'd0, 0, 1'b0, busy);
      chk(lg_n == 1, "R2 one write pulse", lg_n, 1);
      chk(lg_val[0] == c && lg_cle[0] && !lg_ale[0] && lg_oe[0], "R2 command byte", lg_val[0], c);
      chk(re_pulses == 0, "R2 read strobe idle", re_pulses, 0);
      chk(busy == CYC, "R7 command busy length", busy, CYC);
    end

    // R3 address sweep
    for (int p = 0; p < 6; p++) begin
      a = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF : 32'(p * 32'h1357_9BDF + 32'h0F1E_2D3C);
      run_req(1, 8'h00, a, 0, 1'b0, busy);
      chk(lg_n == 4, "R3 four address pulses", lg_n, 4);
      for (int b = 0; b < 4; b++)
        chk(lg_val[b] == a[8*b +: 8] && lg_ale[b] && !lg_cle[b], "R3 address byte order",
            lg_val[b], a[8*b +: 8]);
      chk(busy == 4 * CYC, "R7 address busy length", busy, 4 * CYC);
    end

    // R4 write bursts
    for (int n = 1; n <= 6; n++) begin
      base = widx;
      run_req(2, 8'h00, 32'd0, n, 1'b0, busy);
      chk(lg_n == n, "R4 write pulse count", lg_n, n);
      chk(takes == n, "R4 wr_take count", takes, n);
      for (int b = 0; b < n; b++)
        chk(lg_val[b] == fw(base + b) && !lg_cle[b] && !lg_ale[b] && lg_oe[b], "R4 write byte",
            lg_val[b], fw(base + b));
      chk(busy == n * CYC, "R7 write busy length", busy, n * CYC);
    end

    // R5 read bursts
    for (int n = 1; n <= 7; n++) begin
      run_req(3, 8'h00, 32'd0, (n == 7) ? 15 : n, 1'b0, busy);
      chk(re_pulses == ((n == 7) ? 15 : n), "R5 read pulse count", re_pulses, (n == 7) ? 15 : n);
      chk(rd_n == ((n == 7) ? 15 : n), "R5 rd_valid count", rd_n, (n == 7) ? 15 : n);
      chk(lg_n == 0, "R5 no write pulse", lg_n, 0);
    end

    // R8 zero-length bursts
    for (int k = 2; k <= 3; k++) begin
      run_req(k, 8'h00, 32'd0, 0, 1'b0, busy);
      chk(busy == 0, "R8 zero length completes at once", busy, 0);
      chk(lg_n == 0 && re_pulses == 0 && takes == 0 && rd_n == 0, "R8 no strobe", lg_n + re_pulses, 0);
    end

    // R9 wait flag clear ignores busy pin
    nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    run_req(0, 8'h70, 32'd0, 0, 1'b0, busy);
    chk(busy == CYC, "R9 no wait without flag", busy, CYC);

    // R9 wait released by ready/busy
    fork
      run_req(0, 8'h30, 32'd0, 0, 1'b1, busy);
      begin
        repeat (CYC + 5) @(negedge clk);
        nand_rb = 1'b1;
      end
    join
    chk(busy == CYC + 5 + 2, "R9 ready after busy pin high", busy, CYC + 7);
    chk(tocnt == 0, "R9 no timeout", tocnt, 0);

    // R10 timeout
    nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    run_req(0, 8'hD0, 32'd0, 0, 1'b1, busy);
    chk(busy == CYC + TO, "R10 timeout length", busy, CYC + TO);
    chk(tocnt == 1, "R10 one timeout pulse", tocnt, 1);
    nand_rb = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && nand_ce_n, "R7 idle at end", req_ready, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

endmodule